// File: doc/BRIEF.md
# 40-bit Barrel Shifter with Exponent Detect

This block moves a 40-bit guard-extended word by 0 to 40 bit positions in one clock. It shifts left or right, arithmetic or logical, and registers the result. In the same cycle it measures how many redundant sign bits the operand carries. That count is the exponent: shifting the operand left by it brings the word to normalized form.

A normalize select makes the block use that detected count as its own left-shift distance in the same pass. One cycle then produces both the normalized word and the count needed to record the scaling. Both outputs update on every clock edge. There is no handshake, and a new operand may be presented every cycle.

Top module: `shift_exp40`

## Requirements
- R1: While `rst_n` is low, `result` and `exp_cnt` are both 0.
- R2: With `exp_sel`=0 and `dir_right`=0, `result` after the next rising edge equals `operand` shifted left by `shamt`, with zeros entering at bit 0.
- R3: With `exp_sel`=0, `dir_right`=1 and `arith`=0, `result` equals `operand` shifted right by `shamt`, with zeros entering at bit 39.
- R4: With `exp_sel`=0, `dir_right`=1 and `arith`=1, `result` equals `operand` shifted right by `shamt`, with copies of operand bit 39 entering at the top.
- R5: For a left shift, `arith` has no effect: the result is the same zero-filled value for `arith`=0 and `arith`=1.
- R6: A shift distance of 40 gives all zeros, except for an arithmetic right shift, which gives 40 copies of bit 39. Values of `shamt` from 41 to 63 behave exactly as 40.
- R7: `exp_cnt` is a 6-bit unsigned count of the bits below bit 39 that match bit 39 before the first bit that differs. It equals the number of leading bits equal to bit 39, minus one. An all-zero or all-one operand gives 39. It is reported for every operand, whatever `exp_sel` is.
- R8: With `exp_sel`=1, `result` is `operand` shifted left, zero-filled, by its own exponent count, and `shamt`, `dir_right` and `arith` are ignored. For any operand other than all-zeros and all-ones, bits 39 and 38 of this result differ.
- R9: Each output value reflects the inputs sampled at the preceding rising edge. Back-to-back operands on consecutive cycles each produce their own result one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| operand | input | 40 | Word to shift or measure |
| shamt | input | 6 | Shift distance; values above 40 act as 40 |
| dir_right | input | 1 | 1 = shift right, 0 = shift left |
| arith | input | 1 | 1 = arithmetic (sign fill on right shifts), 0 = logical |
| exp_sel | input | 1 | 1 = normalize: shift left by the detected exponent |
| result | output | 40 | Registered shifted word |
| exp_cnt | output | 6 | Registered redundant-sign-bit count of the operand |

## Verification
Exponent detection and the shift share every cycle. In normalize mode the detected count is also the shift distance, so both functions act on the same operand in the same edge. The bench provokes this with operands whose leading sign run has many different lengths, including single-bit runs, full runs and values one bit short of all-ones. It sets `shamt`, `dir_right` and `arith` to values that would give a different word if they leaked through. Each result is judged against a bit-loop reference that computes the count and the left shift separately. A checker also demands that bits 39 and 38 differ after every normalize of a non-trivial operand.

// File: rtl/shift_exp40.sv
module shift_exp40 #(
  parameter int W  = 40,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  operand,
  input  logic [AW-1:0] shamt,
  input  logic          dir_right,
  input  logic          arith,
  input  logic          exp_sel,
  output logic [W-1:0]  result,
  output logic [AW-1:0] exp_cnt
);

  localparam logic [AW-1:0] WMAX = AW'(W);

  function automatic logic [W-1:0] flip(input logic [W-1:0] v);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = v[W-1-i];
    return r;
  endfunction

  logic [AW-1:0] amt_clamp, exp_c, amt_eff;
  logic          go_right, fill, hit;
  logic [W-1:0]  pre, post;
  logic [AW:0][W-1:0] stg;

  assign amt_clamp = (shamt > WMAX) ? WMAX : shamt;

  always_comb begin
    exp_c = '0;
    hit   = 1'b0;
    for (int i = W-2; i >= 0; i--) begin
      if (!hit) begin
        if (operand[i] == operand[W-1]) exp_c = exp_c + AW'(1);
        else hit = 1'b1;
      end
    end
  end

  assign go_right = dir_right & ~exp_sel;
  assign fill     = go_right & arith & operand[W-1];
  assign amt_eff  = exp_sel ? exp_c : amt_clamp;
  assign pre      = go_right ? operand : flip(operand);
  assign stg[0]   = pre;

  for (genvar k = 0; k < AW; k++) begin : g_stage
    localparam int S = 1 << k;
    if (S < W) begin : g_part
      assign stg[k+1] = amt_eff[k] ? {{S{fill}}, stg[k][W-1:S]} : stg[k];
    end else begin : g_full
      assign stg[k+1] = amt_eff[k] ? {W{fill}} : stg[k];
    end
  end

  assign post = go_right ? stg[AW] : flip(stg[AW]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result  <= '0;
      exp_cnt <= '0;
    end else begin
      result  <= post;
      exp_cnt <= exp_c;
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (result == '0 && exp_cnt == '0));

  assert_cnt_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    exp_cnt <= AW'(W-1));

  assert_norm_top_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (exp_sel && operand != '0 && operand != '1) |=> (result[W-1] != result[W-2]));

  assert_full_left_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!exp_sel && !dir_right && shamt >= WMAX) |=> (result == '0));

  assert_full_arith_sign_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!exp_sel && dir_right && arith && shamt >= WMAX) |=> (result == {W{$past(operand[W-1])}}));

endmodule

// File: tb/shift_exp40_tb.sv
module shift_exp40_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [39:0] operand = '0;
  logic [5:0]  shamt = '0;
  logic        dir_right = 1'b0, arith = 1'b0, exp_sel = 1'b0;
  logic [39:0] result;
  logic [5:0]  exp_cnt;
  int n_chk = 0, n_bad = 0;
  logic [63:0] seed = 64'h1234_5678_9abc_def1;

  always #10 clk = ~clk;

  shift_exp40 dut_i (.clk(clk), .rst_n(rst_n), .operand(operand), .shamt(shamt),
    .dir_right(dir_right), .arith(arith), .exp_sel(exp_sel),
    .result(result), .exp_cnt(exp_cnt));

  function automatic logic [39:0] m_shift(input logic [39:0] v, input int n, input bit right, input bit ar);
    logic [39:0] r;
    int k = (n > 40) ? 40 : n;
    for (int i = 0; i < 40; i++) begin
      if (right) r[i] = (i + k < 40) ? v[i+k] : (ar ? v[39] : 1'b0);
      else       r[i] = (i - k >= 0) ? v[i-k] : 1'b0;
    end
    return r;
  endfunction

  function automatic int m_exp(input logic [39:0] v);
    int c = 0;
    for (int i = 38; i >= 0; i--) begin
      if (v[i] != v[39]) break;
      c++;
    end
    return c;
  endfunction

  function automatic logic [39:0] rnd();
    seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
    return seed[63:24];
  endfunction

  task automatic check(input string tag, input logic [39:0] got, input logic [39:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic run(input string tag, input logic [39:0] op, input int n,
                     input bit right, input bit ar, input bit ex);
    logic [39:0] e_res;
    @(negedge clk);
    operand = op; shamt = 6'(n); dir_right = right; arith = ar; exp_sel = ex;
    e_res = ex ? m_shift(op, m_exp(op), 1'b0, 1'b0) : m_shift(op, n, right, ar);
    @(posedge clk); #2;
    check(tag, result, e_res);
    check({tag, " R7 exp_cnt"}, 40'(exp_cnt), 40'(m_exp(op)));
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0; operand = 40'hF0_1234_5678; shamt = 6'd3;
    @(posedge clk); #2;
    check("R1 result in reset", result, '0);
    check("R1 exp_cnt in reset", 40'(exp_cnt), '0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_left();
    for (int n = 0; n <= 40; n += 3) run("R2 left", rnd(), n, 1'b0, 1'b0, 1'b0);
    run("R2 left by 1", 40'h80_0000_0001, 1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_right_log();
    for (int n = 0; n <= 40; n += 5) run("R3 right logical", rnd() | 40'h80_0000_0000, n, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_right_arith();
    for (int n = 0; n <= 40; n += 4) run("R4 right arith neg", rnd() | 40'h80_0000_0000, n, 1'b1, 1'b1, 1'b0);
    run("R4 right arith pos", 40'h7F_FFFF_FFFF, 39, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_left_arith();
    for (int n = 1; n <= 40; n += 7) run("R5 left with arith set", rnd() | 40'hC0_0000_0000, n, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_range();
    run("R6 left 40", 40'hFF_FFFF_FFFF, 40, 1'b0, 1'b0, 1'b0);
    run("R6 right logical 40", 40'hFF_FFFF_FFFF, 40, 1'b1, 1'b0, 1'b0);
    run("R6 right arith 40 neg", 40'h80_0000_0000, 40, 1'b1, 1'b1, 1'b0);
    run("R6 right arith 40 pos", 40'h7F_FFFF_FFFF, 40, 1'b1, 1'b1, 1'b0);
    run("R6 amount 41 as 40", 40'h9A_BCDE_F012, 41, 1'b1, 1'b1, 1'b0);
    run("R6 amount 63 as 40", 40'h9A_BCDE_F012, 63, 1'b0, 1'b0, 1'b0);
    run("R6 amount 50 logical", 40'h9A_BCDE_F012, 50, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_exponent();
    run("R7 all zeros", 40'h0, 0, 1'b0, 1'b0, 1'b0);
    run("R7 all ones", 40'hFF_FFFF_FFFF, 0, 1'b0, 1'b0, 1'b0);
    run("R7 top bits differ", 40'h40_0000_0000, 0, 1'b0, 1'b0, 1'b0);
    run("R7 minus one-lsb", 40'hFF_FFFF_FFFE, 0, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 39; k += 2)
      run("R7 walking one", 40'(1) << k, 2, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_normalize();
    run("R8 norm zero", 40'h0, 17, 1'b1, 1'b1, 1'b1);
    run("R8 norm all ones", 40'hFF_FFFF_FFFF, 5, 1'b1, 1'b1, 1'b1);
    run("R8 norm one", 40'h00_0000_0001, 7, 1'b1, 1'b1, 1'b1);
    run("R8 norm near-minus", 40'hFF_FFFF_FFFE, 3, 1'b1, 1'b0, 1'b1);
    for (int k = 0; k < 39; k += 3) begin
      run("R8 norm pos run", 40'(1) << k | (rnd() >> (40 - k)), 33, 1'b1, 1'b1, 1'b1);
      run("R8 norm neg run", ~(40'(1) << k), 12, 1'b0, 1'b1, 1'b1);
    end
    for (int k = 0; k < 6; k++) begin
      logic [39:0] v = rnd() >> (k * 6);
      run("R8 norm random", v, 40, 1'b1, 1'b1, 1'b1);
      check("R8 top bits differ", 40'(result[39] ^ result[38]), 40'((v != 0 && v != '1) ? 1 : 0));
    end
  endtask

  task automatic t_back_to_back();
    for (int k = 0; k < 20; k++)
      run("R9 back-to-back", rnd(), k * 3 % 44, k[0], k[1], k[2]);
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_left();
    t_right_log();
    t_right_arith();
    t_left_arith();
    t_range();
    t_exponent();
    t_normalize();
    t_back_to_back();
    t_reset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule